// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Preemption

This block sits between a set of interrupt sources and one processor. Each source is given a fixed vector equal to its index: the software-triggered sources take vectors 0 to 7 and the peripheral sources take vector 8 and above. Each source also has a programmable 4-bit priority. On every cycle the block looks at the asserted requests and finds the highest priority among them. When several requests share that priority, it picks the one with the lowest vector. It then compares the winner's priority against the processor's current priority. Priority 0 is the lowest level, and a source at priority 0 never takes part.

The block raises its interrupt line only when the winner's priority is strictly greater than the current priority. The winner's vector always goes to the acknowledge output. A copy of it goes to the hardware-vector output only when hardware-vector mode is enabled. All three outputs are registered.

A single write port loads the per-source priorities, the current priority and the mode bit.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, irq_o, ack_vec_o and hw_vec_o are 0, every source priority is 0, the current priority is 0 and hardware-vector mode is off.
- R2: Among the asserted requests that have a nonzero priority, the winner is the one with the highest priority. Its vector equals its source index, including index 0.
- R3: When several eligible requests share the highest priority, the winner is the one with the lowest vector, whatever order the requests were asserted in.
- R4: irq_o is 1 only when the winner's priority is strictly greater than the current priority. If the two are equal, or the winner's priority is lower, irq_o is 0.
- R5: An asserted request whose priority is 0 is never chosen and never raises irq_o.
- R6: With no eligible request, irq_o is 0, ack_vec_o is 0 and hw_vec_o is 0.
- R7: The outputs are registered. A change on req_i shows up after the first rising edge that follows it. A register write takes effect at the edge where it is accepted, so the outputs follow one edge later.
- R8: hw_vec_o carries the winner's vector when the mode bit is 1, and is 0 when the mode bit is 0. ack_vec_o carries the winner's vector in both modes.
- R9: Write decoding depends on wr_addr_i. An address below N_SRC loads that source's priority from wr_data_i. Address N_SRC loads the current priority. Address N_SRC+1 loads the mode bit from wr_data_i[0]. Any higher address is ignored.
- R10: ack_vec_o reports the winner's vector even when irq_o is 0 because the winner does not exceed the current priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Asserted interrupt requests, bit i is vector i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address (source priority, current priority, mode) |
| wr_data_i | input | PRIO_W | Write data |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_vec_o | output | VEC_W | Winner vector for the acknowledge register |
| hw_vec_o | output | VEC_W | Winner vector when hardware-vector mode is on, else 0 |

## Verification
The hardest case to reach is a three-way tie at the top priority. It must resolve to the lowest vector even when that source is asserted last. The stimulus programs equal priorities and raises the requests from the highest vector down, checking each step. It then repeats the test in the opposite order.

A second hard case is the strict comparison. The current priority is swept to one below, equal to, and above the winner's priority, and the acknowledge vector is checked to stay valid while irq_o is low. A write to an unused address is made while a priority-0 source is asserted at the aliased index, so that a faulty decode would change the winner.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Decoded meaning of one register write.
  typedef enum logic [1:0] {
    WR_NONE     = 2'd0,
    WR_SRC_PRIO = 2'd1,
    WR_CUR_PRIO = 2'd2,
    WR_MODE     = 2'd3
  } wr_kind_e;

  // Address width that covers N_SRC source slots plus the two control slots.
  function automatic int addr_width(input int n_src);
    return $clog2(n_src + 2);
  endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [PRIO_W-1:0]              wr_data_i,
  output logic [N_SRC-1:0][PRIO_W-1:0]   prio_o,
  output logic [PRIO_W-1:0]              cur_prio_o,
  output logic                           hw_mode_o
);

  localparam logic [ADDR_W-1:0] CUR_ADDR  = ADDR_W'(N_SRC);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(N_SRC + 1);

  wr_kind_e          wr_kind;
  logic [N_SRC-1:0]  src_sel;
  logic [PRIO_W-1:0] cur_prio_d;
  logic              cur_prio_en;
  logic              hw_mode_d;
  logic              hw_mode_en;

  // Write decode
  always_comb begin
    wr_kind = WR_NONE;
    if (wr_en_i) begin
      if (wr_addr_i < CUR_ADDR)       wr_kind = WR_SRC_PRIO;
      else if (wr_addr_i == CUR_ADDR) wr_kind = WR_CUR_PRIO;
      else if (wr_addr_i == MODE_ADDR) wr_kind = WR_MODE;
      else                            wr_kind = WR_NONE;
    end
  end

  // Per-source priority registers
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic              en;
    logic [PRIO_W-1:0] q;

    assign src_sel[g] = (wr_kind == WR_SRC_PRIO) && (wr_addr_i == ADDR_W'(g));
    assign en         = src_sel[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data_i;
    end

    assign prio_o[g] = q;
  end

  // Current priority and mode: next state
  always_comb begin
    cur_prio_en = (wr_kind == WR_CUR_PRIO);
    cur_prio_d  = wr_data_i;
    hw_mode_en  = (wr_kind == WR_MODE);
    hw_mode_d   = wr_data_i[0];
  end

  // Current priority and mode: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prio_o <= '0;
      hw_mode_o  <= 1'b0;
    end else begin
      if (cur_prio_en) cur_prio_o <= cur_prio_d;
      if (hw_mode_en)  hw_mode_o  <= hw_mode_d;
    end
  end

  // R9: at most one source priority slot loads on any cycle
  a_r9_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel));

  // R9: a write beyond the mode slot leaves the control registers unchanged
  a_r9_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i > MODE_ADDR) |=> ($stable(cur_prio_o) && $stable(hw_mode_o)));

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         win_valid_o,
  output logic [PRIO_W-1:0]            win_prio_o,
  output logic [VEC_W-1:0]             win_vec_o
);

  logic [N_SRC-1:0]  eligible;
  logic [N_SRC-1:0]  top_set;
  logic [PRIO_W-1:0] top_prio;

  // Only asserted sources with nonzero priority compete
  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign eligible[g] = req_i[g] && (prio_i[g] != '0);
  end

  // Stage 1: highest priority among eligible sources
  always_comb begin
    top_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (eligible[i] && (prio_i[i] > top_prio)) top_prio = prio_i[i];
    end
  end

  // Stage 2: all eligible sources sitting at that priority
  for (genvar g = 0; g < N_SRC; g++) begin : g_top
    assign top_set[g] = eligible[g] && (prio_i[g] == top_prio);
  end

  // Stage 3: lowest index wins among the top set
  always_comb begin
    win_vec_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (top_set[i]) win_vec_o = VEC_W'(i);
    end
  end

  assign win_valid_o = |eligible;
  assign win_prio_o  = top_prio;

  // Independent cross-check flags for the assertions below
  logic beaten_hi;
  logic beaten_tie;
  always_comb begin
    beaten_hi  = 1'b0;
    beaten_tie = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (prio_i[i] != '0) && (prio_i[i] > win_prio_o)) beaten_hi = 1'b1;
      if (req_i[i] && (prio_i[i] != '0) && (prio_i[i] == win_prio_o) &&
          (VEC_W'(i) < win_vec_o)) beaten_tie = 1'b1;
    end
  end

  // R2: no eligible source outranks the winner
  a_r2_highest: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> !beaten_hi);

  // R3: no lower vector at the same priority is passed over
  a_r3_lowest_vec: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> !beaten_tie);

  // R5: a valid winner never carries priority 0
  a_r5_zero_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (win_prio_o != '0));

  // R6: no candidate means vector 0
  a_r6_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_o |-> (win_vec_o == '0));

endmodule

// File: rtl/irq_prio_out.sv
module irq_prio_out #(
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  input  logic [VEC_W-1:0]  win_vec_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              hw_mode_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic [VEC_W-1:0]  hw_vec_o
);

  logic             irq_d;
  logic [VEC_W-1:0] ack_vec_d;
  logic [VEC_W-1:0] hw_vec_d;
  logic             out_en;

  // Next state: strict preemption compare and vector gating
  always_comb begin
    out_en    = 1'b1;
    irq_d     = win_valid_i && (win_prio_i > cur_prio_i);
    ack_vec_d = win_valid_i ? win_vec_i : '0;
    hw_vec_d  = hw_mode_i ? ack_vec_d : '0;
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      ack_vec_o <= '0;
      hw_vec_o  <= '0;
    end else if (out_en) begin
      irq_o     <= irq_d;
      ack_vec_o <= ack_vec_d;
      hw_vec_o  <= hw_vec_d;
    end
  end

  // R4: a winner not above the current priority leaves the line low
  a_r4_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid_i && (win_prio_i <= cur_prio_i)) |=> !irq_o);

  // R6: with nothing eligible every output goes idle
  a_r6_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_i |=> (!irq_o && (ack_vec_o == '0) && (hw_vec_o == '0)));

  // R8: mode off forces the hardware vector to 0
  a_r8_hw_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_mode_i |=> (hw_vec_o == '0));

  // R10: acknowledge vector tracks the winner even without an interrupt
  a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_i |=> (ack_vec_o == $past(win_vec_i)));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 9,
  parameter int ADDR_W = irq_arb_pkg::addr_width(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PRIO_W-1:0] wr_data_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic [VEC_W-1:0]  hw_vec_o
);

  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [PRIO_W-1:0]            cur_prio;
  logic                         hw_mode;
  logic                         win_valid;
  logic [PRIO_W-1:0]            win_prio;
  logic [VEC_W-1:0]             win_vec;

  irq_prio_regs #(
    .N_SRC  (N_SRC),
    .PRIO_W (PRIO_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .prio_o     (prio),
    .cur_prio_o (cur_prio),
    .hw_mode_o  (hw_mode)
  );

  irq_prio_select #(
    .N_SRC  (N_SRC),
    .PRIO_W (PRIO_W),
    .VEC_W  (VEC_W)
  ) u_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .prio_i      (prio),
    .win_valid_o (win_valid),
    .win_prio_o  (win_prio),
    .win_vec_o   (win_vec)
  );

  irq_prio_out #(
    .PRIO_W (PRIO_W),
    .VEC_W  (VEC_W)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_valid_i (win_valid),
    .win_prio_i  (win_prio),
    .win_vec_i   (win_vec),
    .cur_prio_i  (cur_prio),
    .hw_mode_i   (hw_mode),
    .irq_o       (irq_o),
    .ack_vec_o   (ack_vec_o),
    .hw_vec_o    (hw_vec_o)
  );

  // R1: the interrupt line is low on the first cycle after reset release
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o);

endmodule

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N_SRC  = 32;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 9;
  localparam int ADDR_W = 6;
  localparam int CUR_A  = N_SRC;
  localparam int MODE_A = N_SRC + 1;

  logic              clk;
  logic              rst_n;
  logic [N_SRC-1:0]  req;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [PRIO_W-1:0] wr_data;
  logic              irq;
  logic [VEC_W-1:0]  ack_vec;
  logic [VEC_W-1:0]  hw_vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_prio_arbiter #(
    .N_SRC  (N_SRC),
    .PRIO_W (PRIO_W),
    .VEC_W  (VEC_W),
    .ADDR_W (ADDR_W)
  ) i_irq_prio_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .irq_o     (irq),
    .ack_vec_o (ack_vec),
    .hw_vec_o  (hw_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = PRIO_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_req(input logic [N_SRC-1:0] v);
    @(negedge clk);
    req = v;
    @(negedge clk);
  endtask

  task automatic clear_all();
    req = '0;
    for (int i = 0; i < N_SRC; i++) wr(i, 0);
    wr(CUR_A, 0);
    wr(MODE_A, 0);
    settle();
  endtask

  task automatic t_reset();
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "ack_vec after reset", ack_vec, 0);
    chk("R1", "hw_vec after reset", hw_vec, 0);
    set_req('1);
    chk("R1", "irq with all priorities reset to 0", irq, 0);
    set_req('0);
  endtask

  task automatic t_highest();
    wr(5, 3); wr(12, 7); wr(20, 2);
    set_req((32'd1 << 5) | (32'd1 << 12) | (32'd1 << 20));
    chk("R2", "irq", irq, 1);
    chk("R2", "ack_vec winner", ack_vec, 12);
    chk("R8", "hw_vec with mode off", hw_vec, 0);
    wr(MODE_A, 1); settle();
    chk("R8", "hw_vec with mode on", hw_vec, 12);
    chk("R8", "ack_vec with mode on", ack_vec, 12);
    wr(0, 1);
    set_req(32'd1);
    chk("R2", "vector 0 winner ack", ack_vec, 0);
    chk("R2", "vector 0 winner irq", irq, 1);
    chk("R8", "vector 0 hw_vec", hw_vec, 0);
    clear_all();
  endtask

  task automatic t_ties();
    wr(3, 9); wr(17, 9); wr(25, 9); wr(4, 8);
    set_req((32'd1 << 25) | (32'd1 << 4));
    chk("R3", "tie stage 1", ack_vec, 25);
    set_req((32'd1 << 25) | (32'd1 << 17) | (32'd1 << 4));
    chk("R3", "tie stage 2", ack_vec, 17);
    set_req((32'd1 << 25) | (32'd1 << 17) | (32'd1 << 3) | (32'd1 << 4));
    chk("R3", "tie stage 3", ack_vec, 3);
    set_req(32'd1 << 3);
    set_req((32'd1 << 3) | (32'd1 << 25));
    chk("R3", "tie reverse order", ack_vec, 3);
    clear_all();
  endtask

  task automatic t_threshold();
    wr(3, 9);
    set_req(32'd1 << 3);
    wr(CUR_A, 8); settle();
    chk("R4", "irq winner above current", irq, 1);
    wr(CUR_A, 9); settle();
    chk("R4", "irq winner equal current", irq, 0);
    chk("R10", "ack_vec with irq low", ack_vec, 3);
    wr(CUR_A, 15); settle();
    chk("R4", "irq winner below current", irq, 0);
    chk("R10", "ack_vec below current", ack_vec, 3);
    wr(3, 15); settle();
    chk("R4", "irq at maximum equal", irq, 0);
    clear_all();
  endtask

  task automatic t_zero_prio();
    set_req(32'd1 << 30);
    chk("R5", "irq from priority 0", irq, 0);
    chk("R5", "ack_vec from priority 0", ack_vec, 0);
    wr(6, 2);
    set_req((32'd1 << 30) | (32'd1 << 6));
    chk("R5", "priority 0 loses to 6", ack_vec, 6);
    clear_all();
  endtask

  task automatic t_idle();
    wr(MODE_A, 1); wr(9, 4);
    set_req(32'd1 << 9);
    chk("R6", "pre-idle hw_vec", hw_vec, 9);
    set_req('0);
    chk("R6", "idle irq", irq, 0);
    chk("R6", "idle ack_vec", ack_vec, 0);
    chk("R6", "idle hw_vec", hw_vec, 0);
    clear_all();
  endtask

  task automatic t_latency();
    wr(12, 7); settle();
    @(negedge clk);
    req = 32'd1 << 12;
    #1;
    chk("R7", "irq before edge", irq, 0);
    @(negedge clk);
    chk("R7", "irq after one edge", irq, 1);
    wr(12, 0);
    chk("R7", "irq on write edge", irq, 1);
    settle();
    chk("R7", "irq one edge after write", irq, 0);
    clear_all();
  endtask

  task automatic t_decode();
    wr(12, 7);
    set_req((32'd1 << 12) | (32'd1 << 8));
    chk("R9", "setup winner", ack_vec, 12);
    wr(40, 15); settle();
    chk("R9", "ack_vec after unused address", ack_vec, 12);
    chk("R9", "irq after unused address", irq, 1);
    wr(CUR_A, 7); settle();
    chk("R9", "current priority slot", irq, 0);
    wr(MODE_A, 1); settle();
    chk("R9", "mode slot", hw_vec, 12);
    clear_all();
  endtask

  initial begin
    rst_n   = 1'b0;
    req     = '0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_highest();
    t_ties();
    t_threshold();
    t_zero_prio();
    t_idle();
    t_latency();
    t_decode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule